// File: doc/BRIEF.md
# Register-Mapped Serial Port with FIFOs

This block is a memory-mapped asynchronous serial port. A host writes bytes into a transmit queue through a narrow register window, and the block sends them one frame at a time on a single output line. A single input line is watched for incoming frames, which are decoded into bytes and queued for the host. Each received byte carries its own framing, parity and overrun status. After the host reads the byte, it reads that status from a separate register.

Line timing comes from a 12-bit divisor with 16x oversampling. The divisor is split over two registers: one holds the low byte and the other holds the top nibble. A line-control byte sets the word length (5 to 8 bits), parity on or off, even or odd parity, one or two stop bits, a forced-low break, and the queue depth. The queues hold 16 entries when enabled and one entry when disabled. An enable register parks the port, so that software can change the divisor and line format safely, and restarts it with the new settings.

Two level-sensitive interrupt outputs are provided. The receive request stays high while received data waits. The transmit request stays high while the transmit queue can accept another byte.

Top module: `uart_regport`

## Requirements
- R1: One bit on the line lasts 16 x (D + 1) clock cycles. D is the 12-bit divisor: its bits 7:0 come from the register at word address 4, and its bits 11:8 come from bits 3:0 of the register at word address 5. The upper bits of that second write are ignored.
- R2: A transmitted frame has these parts, in order: a low start bit, then the data bits LSB first, then an optional parity bit, then one or two high stop bits. The line rests high between frames. The line-control register is at word address 6. Its bits 6:5 give the word length: 0 = 5 bits, 1 = 6, 2 = 7, 3 = 8. Bit 1 enables parity. Bit 2 selects even parity when set and odd parity when clear. Bit 3 selects two stop bits.
- R3: While line-control bit 0 is set, the transmit line is held low from the next cycle onward.
- R4: Line-control bit 4 sets both queues to 16 entries. When it is clear, each queue holds a single entry. A write to the data register (word address 0) while the transmit queue is full is dropped.
- R5: The flag register is at word address 2. Bit 3 is set while a frame is being sent or transmit data is queued. Bit 4 is set while the receive queue is empty. Bit 5 is set while the transmit queue is full. All other bits read 0.
- R6: A read of word address 0 returns the oldest received byte and removes it from the queue. Reading an empty queue returns 0 and has no effect. The register at word address 1 then shows the status of the byte just read: bit 0 is the framing error, bit 1 the parity error, and bit 2 the overrun.
- R7: The receiver samples each bit at the 8th of its 16 oversample ticks. If the stop bit is sampled low, the byte is stored with its framing error set.
- R8: Parity is checked only when parity is enabled. It covers exactly the configured data bits. A mismatch stores the byte with its parity error set.
- R9: A frame that completes while the receive queue is full is discarded. The next byte that is stored carries the overrun flag.
- R10: The enable register is at word address 3, bit 0. Writing 0 parks both directions: the line goes high (unless a break is set), both queues are flushed, and data writes and incoming frames are ignored. Writing 1 resumes operation with the current settings.
- R11: `irq_rx` is high while the receive queue holds data. `irq_tx` is high while the port is enabled and the transmit queue is not full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Register access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Word address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from the address |
| tx_o | output | 1 | Serial transmit line |
| rx_i | input | 1 | Serial receive line (asynchronous) |
| irq_rx | output | 1 | Receive data waiting |
| irq_tx | output | 1 | Transmit queue has room |

## Verification
The embedded properties assume that software changes the divisor and the queue-depth bit only while the port is parked. The tick-spacing and single-entry checks rely on those fields staying constant during operation. The stimulus always takes the disable, program, re-enable path before changing the format, and toggles only the break bit while the port runs. The properties also assume that each incoming frame on `rx_i` is held for whole bit times at the programmed rate. The bench drives its frames with the same divisor it has programmed into the port.

// File: rtl/uart_pkg.sv
package uart_pkg;

    localparam logic [2:0] A_DATA   = 3'd0;
    localparam logic [2:0] A_RXERR  = 3'd1;
    localparam logic [2:0] A_FLAGS  = 3'd2;
    localparam logic [2:0] A_ENABLE = 3'd3;
    localparam logic [2:0] A_DIVLO  = 3'd4;
    localparam logic [2:0] A_DIVHI  = 3'd5;
    localparam logic [2:0] A_LINE   = 3'd6;

    localparam int FLAG_BUSY = 3;
    localparam int FLAG_RXE  = 4;
    localparam int FLAG_TXF  = 5;

    typedef struct packed {
        logic [1:0] wlen;
        logic       fifo_en;
        logic       stop2;
        logic       par_even;
        logic       par_en;
        logic       brk;
    } line_cfg_t;

    typedef struct packed {
        logic ovr;
        logic par;
        logic frm;
    } rx_err_t;

    typedef struct packed {
        rx_err_t    err;
        logic [7:0] data;
    } rx_entry_t;

    typedef enum logic [2:0] {
        S_IDLE, S_START, S_DATA, S_PAR, S_STOP
    } frame_st_t;

    function automatic line_cfg_t decode_line(input logic [7:0] v);
        line_cfg_t c;
        c.brk      = v[0];
        c.par_en   = v[1];
        c.par_even = v[2];
        c.stop2    = v[3];
        c.fifo_en  = v[4];
        c.wlen     = v[6:5];
        return c;
    endfunction

    // index of the final data bit for a word-length code
    function automatic logic [2:0] last_bit(input logic [1:0] wl);
        return {1'b0, wl} + 3'd4;
    endfunction

    function automatic logic parity_bit(input logic [7:0] d, input logic [1:0] wl,
                                        input logic even);
        logic p;
        p = ^(d & (8'hFF >> (2'd3 - wl)));
        return even ? p : ~p;
    endfunction

endpackage

// File: rtl/uart_fifo.sv
module uart_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         flush,
    input  logic         one_deep,
    input  logic         push,
    input  logic [W-1:0] wdata,
    input  logic         pop,
    output logic [W-1:0] rdata,
    output logic         empty,
    output logic         full
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] rp, wp;
    logic [CW-1:0] cnt;
    logic          do_push, do_pop;

    assign empty   = (cnt == '0);
    assign full    = one_deep ? !empty : (cnt == CW'(DEPTH));
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign rdata   = mem[rp];

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            rp  <= '0;
            wp  <= '0;
            cnt <= '0;
        end else begin
            if (do_push) wp <= wp + AW'(1);
            if (do_pop)  rp <= rp + AW'(1);
            cnt <= cnt + CW'(do_push) - CW'(do_pop);
        end
    end

    always_ff @(posedge clk) begin
        if (do_push && !flush) mem[wp] <= wdata;
    end

    assert_single_entry_R4: assert property (@(posedge clk) disable iff (rst)
        (one_deep && !flush) |-> (cnt <= CW'(1)));

    assert_last_pop_empties_R6: assert property (@(posedge clk) disable iff (rst)
        (do_pop && !do_push && !flush && cnt == CW'(1)) |=> empty);

endmodule

// File: rtl/uart_baud.sv
module uart_baud #(
    parameter int DW = 12
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          run,
    input  logic          restart,
    input  logic [DW-1:0] div,
    output logic          tick
);
    logic [DW-1:0] cnt;

    assign tick = run && !restart && (cnt >= div);

    always_ff @(posedge clk) begin
        if (rst || !run || restart || tick) cnt <= '0;
        else                                cnt <= cnt + DW'(1);
    end

    assert_tick_spacing_R1: assert property (@(posedge clk) disable iff (rst)
        (tick && div != '0 && $stable(div)) |=> !tick);

endmodule

// File: rtl/uart_tx.sv
module uart_tx import uart_pkg::*; (
    input  logic       clk,
    input  logic       rst,
    input  logic       run,
    input  logic       tick,
    input  logic       brk,
    input  logic       par_en,
    input  logic       par_even,
    input  logic       stop2,
    input  logic [1:0] wlen,
    input  logic       have_data,
    input  logic [7:0] din,
    output logic       pop,
    output logic       busy,
    output logic       txd
);
    frame_st_t  st;
    logic [3:0] sub;
    logic [2:0] bitn;
    logic [7:0] sh;
    logic       pb, second, line;

    assign pop  = run && (st == S_IDLE) && have_data;
    assign busy = (st != S_IDLE);

    always_comb begin
        case (st)
            S_START: line = 1'b0;
            S_DATA:  line = sh[0];
            S_PAR:   line = pb;
            default: line = 1'b1;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) txd <= 1'b1;
        else     txd <= !brk && line;
    end

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            st     <= S_IDLE;
            sub    <= '0;
            bitn   <= '0;
            sh     <= '0;
            pb     <= 1'b0;
            second <= 1'b0;
        end else if (pop) begin
            st     <= S_START;
            sub    <= '0;
            bitn   <= '0;
            sh     <= din;
            pb     <= parity_bit(din, wlen, par_even);
            second <= 1'b0;
        end else if (st != S_IDLE && tick) begin
            sub <= sub + 4'd1;
            if (sub == 4'd15) begin
                case (st)
                    S_START: st <= S_DATA;
                    S_DATA: begin
                        sh <= sh >> 1;
                        if (bitn == last_bit(wlen)) st <= par_en ? S_PAR : S_STOP;
                        else                        bitn <= bitn + 3'd1;
                    end
                    S_PAR: st <= S_STOP;
                    S_STOP: begin
                        if (stop2 && !second) second <= 1'b1;
                        else                  st <= S_IDLE;
                    end
                    default: st <= S_IDLE;
                endcase
            end
        end
    end

    assert_break_low_R3: assert property (@(posedge clk) disable iff (rst)
        $past(brk) |-> !txd);

    assert_idle_high_R2: assert property (@(posedge clk) disable iff (rst)
        ($past(st) == S_IDLE && !$past(brk)) |-> txd);

endmodule

// File: rtl/uart_rx.sv
module uart_rx import uart_pkg::*; (
    input  logic       clk,
    input  logic       rst,
    input  logic       run,
    input  logic       tick,
    input  logic       rxd,
    input  logic       par_en,
    input  logic       par_even,
    input  logic [1:0] wlen,
    output logic       restart,
    output logic       valid,
    output logic [7:0] data,
    output logic       frm_err,
    output logic       par_err
);
    frame_st_t  st;
    logic [3:0] sub;
    logic [2:0] bitn;
    logic       s1, s2, s3;
    logic       mid, last;

    assign restart = run && (st == S_IDLE) && s3 && !s2;
    assign mid     = (sub == 4'd7);
    assign last    = (sub == 4'd15);

    always_ff @(posedge clk) begin
        if (rst) begin
            s1 <= 1'b1;
            s2 <= 1'b1;
            s3 <= 1'b1;
        end else begin
            s1 <= rxd;
            s2 <= s1;
            s3 <= s2;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            st      <= S_IDLE;
            sub     <= '0;
            bitn    <= '0;
            valid   <= 1'b0;
            data    <= '0;
            frm_err <= 1'b0;
            par_err <= 1'b0;
        end else begin
            valid <= 1'b0;
            if (restart) begin
                st      <= S_START;
                sub     <= '0;
                bitn    <= '0;
                data    <= '0;
                frm_err <= 1'b0;
                par_err <= 1'b0;
            end else if (st != S_IDLE && tick) begin
                sub <= sub + 4'd1;
                case (st)
                    S_START: begin
                        if (mid && s2)  st <= S_IDLE;
                        else if (last)  st <= S_DATA;
                    end
                    S_DATA: begin
                        if (mid) data[bitn] <= s2;
                        if (last) begin
                            if (bitn == last_bit(wlen)) st <= par_en ? S_PAR : S_STOP;
                            else                        bitn <= bitn + 3'd1;
                        end
                    end
                    S_PAR: begin
                        if (mid)  par_err <= (s2 != parity_bit(data, wlen, par_even));
                        if (last) st <= S_STOP;
                    end
                    S_STOP: begin
                        if (mid) begin
                            frm_err <= !s2;
                            valid   <= 1'b1;
                            st      <= S_IDLE;
                        end
                    end
                    default: st <= S_IDLE;
                endcase
            end
        end
    end

    assert_single_valid_R6: assert property (@(posedge clk) disable iff (rst)
        valid |=> !valid);

endmodule

// File: rtl/uart_regport.sv
module uart_regport import uart_pkg::*; #(
    parameter int FIFO_DEPTH = 16,
    parameter int DIV_W      = 12
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        bus_sel,
    input  logic        bus_wr,
    input  logic [2:0]  bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    output logic        tx_o,
    input  logic        rx_i,
    output logic        irq_rx,
    output logic        irq_tx
);
    localparam int HI_W = DIV_W - 8;
    localparam int EW   = $bits(rx_entry_t);

    logic            en_q, ovr_pend;
    logic [7:0]      div_lo, line_q;
    logic [HI_W-1:0] div_hi;
    rx_err_t         err_q;
    line_cfg_t       cfg;
    logic [DIV_W-1:0] div;
    logic            wr, rd;
    logic            unused_wdata_hi;

    logic            txf_push, txf_empty, txf_full, tx_pop, tx_busy, tx_tick;
    logic [7:0]      txf_data;
    logic            rx_restart, rx_tick, rx_valid, rx_frm, rx_par;
    logic [7:0]      rx_data;
    logic            rxf_push, rxf_pop, rxf_empty, rxf_full;
    rx_entry_t       rx_in, rx_head;
    logic [EW-1:0]   rx_head_bits;

    assign cfg             = decode_line(line_q);
    assign div             = {div_hi, div_lo};
    assign wr              = bus_sel && bus_wr;
    assign rd              = bus_sel && !bus_wr;
    assign unused_wdata_hi = ^bus_wdata[31:8];

    assign txf_push = wr && (bus_addr == A_DATA) && en_q;
    assign rxf_pop  = rd && (bus_addr == A_DATA) && !rxf_empty;
    assign rxf_push = rx_valid && !rxf_full;
    assign rx_in    = '{err: '{ovr: ovr_pend, par: rx_par, frm: rx_frm}, data: rx_data};
    assign rx_head  = rx_entry_t'(rx_head_bits);

    assign irq_rx = !rxf_empty;
    assign irq_tx = en_q && !txf_full;

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q     <= 1'b0;
            div_lo   <= '0;
            div_hi   <= '0;
            line_q   <= '0;
            err_q    <= '0;
            ovr_pend <= 1'b0;
        end else begin
            if (wr) begin
                case (bus_addr)
                    A_ENABLE: en_q   <= bus_wdata[0];
                    A_DIVLO:  div_lo <= bus_wdata[7:0];
                    A_DIVHI:  div_hi <= bus_wdata[HI_W-1:0];
                    A_LINE:   line_q <= bus_wdata[7:0];
                    default:  ;
                endcase
            end
            if (rxf_pop) err_q <= rx_head.err;
            if (!en_q)                       ovr_pend <= 1'b0;
            else if (rx_valid && rxf_full)   ovr_pend <= 1'b1;
            else if (rxf_push)               ovr_pend <= 1'b0;
        end
    end

    always_comb begin
        case (bus_addr)
            A_DATA:   bus_rdata = rxf_empty ? 32'd0 : {24'd0, rx_head.data};
            A_RXERR:  bus_rdata = {29'd0, err_q};
            A_FLAGS: begin
                bus_rdata            = '0;
                bus_rdata[FLAG_BUSY] = tx_busy || !txf_empty;
                bus_rdata[FLAG_RXE]  = rxf_empty;
                bus_rdata[FLAG_TXF]  = txf_full;
            end
            A_ENABLE: bus_rdata = {31'd0, en_q};
            A_DIVLO:  bus_rdata = {24'd0, div_lo};
            A_DIVHI:  bus_rdata = {{(32 - HI_W){1'b0}}, div_hi};
            A_LINE:   bus_rdata = {24'd0, line_q};
            default:  bus_rdata = '0;
        endcase
    end

    uart_fifo #(.W(8), .DEPTH(FIFO_DEPTH)) u_txq (
        .clk(clk), .rst(rst), .flush(!en_q), .one_deep(!cfg.fifo_en),
        .push(txf_push), .wdata(bus_wdata[7:0]), .pop(tx_pop),
        .rdata(txf_data), .empty(txf_empty), .full(txf_full)
    );

    uart_fifo #(.W(EW), .DEPTH(FIFO_DEPTH)) u_rxq (
        .clk(clk), .rst(rst), .flush(!en_q), .one_deep(!cfg.fifo_en),
        .push(rxf_push), .wdata(rx_in), .pop(rxf_pop),
        .rdata(rx_head_bits), .empty(rxf_empty), .full(rxf_full)
    );

    uart_baud #(.DW(DIV_W)) u_tx_baud (
        .clk(clk), .rst(rst), .run(en_q), .restart(tx_pop), .div(div), .tick(tx_tick)
    );

    uart_baud #(.DW(DIV_W)) u_rx_baud (
        .clk(clk), .rst(rst), .run(en_q), .restart(rx_restart), .div(div), .tick(rx_tick)
    );

    uart_tx u_tx (
        .clk(clk), .rst(rst), .run(en_q), .tick(tx_tick), .brk(cfg.brk),
        .par_en(cfg.par_en), .par_even(cfg.par_even), .stop2(cfg.stop2), .wlen(cfg.wlen),
        .have_data(!txf_empty), .din(txf_data), .pop(tx_pop), .busy(tx_busy), .txd(tx_o)
    );

    uart_rx u_rx (
        .clk(clk), .rst(rst), .run(en_q), .tick(rx_tick), .rxd(rx_i),
        .par_en(cfg.par_en), .par_even(cfg.par_even), .wlen(cfg.wlen),
        .restart(rx_restart), .valid(rx_valid), .data(rx_data),
        .frm_err(rx_frm), .par_err(rx_par)
    );

    assert_overrun_marks_next_R9: assert property (@(posedge clk) disable iff (rst)
        (rx_valid && rxf_full) |=> (ovr_pend || !en_q));

    assert_parked_queues_empty_R10: assert property (@(posedge clk) disable iff (rst)
        (!en_q && !$past(en_q)) |-> (rxf_empty && txf_empty));

endmodule

// File: tb/uart_regport_test.sv
module uart_regport_test;
    localparam int CLK_P  = 10;
    localparam int BITCLK = 32;   // divisor 1

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_sel = 1'b0, bus_wr = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        tx_o, irq_rx, irq_tx;
    logic        rx_i = 1'b1;
    int          total = 0, bad = 0;

    always #(CLK_P/2) clk = ~clk;

    uart_regport uut (
        .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tx_o(tx_o), .rx_i(rx_i),
        .irq_rx(irq_rx), .irq_tx(irq_tx)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
        end
    endtask

    task automatic bus_write(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #1;
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        @(posedge clk); #1;
        bus_sel = 1'b0;
    endtask

    task automatic configure(input logic [7:0] lo, input logic [7:0] hi, input logic [7:0] line);
        bus_write(3'd3, 32'd0);
        bus_write(3'd4, {24'd0, lo});
        bus_write(3'd5, {24'd0, hi});
        bus_write(3'd6, {24'd0, line});
        bus_write(3'd3, 32'd1);
    endtask

    task automatic capture(input int bc, input int nb, input bit has_par, input int nstop,
                           output logic [7:0] d, output logic p, output logic framing_ok);
        d = '0; p = 1'b0;
        @(negedge clk);
        while (tx_o !== 1'b0) @(negedge clk);
        repeat (bc/2) @(negedge clk);
        framing_ok = (tx_o == 1'b0);
        for (int i = 0; i < nb; i++) begin
            repeat (bc) @(negedge clk);
            d[i] = tx_o;
        end
        if (has_par) begin
            repeat (bc) @(negedge clk);
            p = tx_o;
        end
        for (int i = 0; i < nstop; i++) begin
            repeat (bc) @(negedge clk);
            if (tx_o !== 1'b1) framing_ok = 1'b0;
        end
    endtask

    task automatic send_rx(input int bc, input logic [7:0] v, input int nb,
                           input bit has_par, input logic pbit, input logic stopv);
        @(negedge clk);
        rx_i = 1'b0;
        repeat (bc) @(negedge clk);
        for (int i = 0; i < nb; i++) begin
            rx_i = v[i];
            repeat (bc) @(negedge clk);
        end
        if (has_par) begin
            rx_i = pbit;
            repeat (bc) @(negedge clk);
        end
        rx_i = stopv;
        repeat (bc) @(negedge clk);
        rx_i = 1'b1;
        repeat (bc) @(negedge clk);
    endtask

    task automatic t_reset;
        logic [31:0] r;
        bus_read(3'd2, r);
        check("R5", "flags after reset", r, 32'h10);
        check("R10", "tx line idle after reset", tx_o, 1);
        check("R11", "irq_rx after reset", irq_rx, 0);
        check("R11", "irq_tx while parked", irq_tx, 0);
    endtask

    task automatic t_tx_8n1;
        logic [7:0] d; logic p, ok;
        configure(8'd1, 8'd0, 8'h60);
        fork
            capture(BITCLK, 8, 0, 1, d, p, ok);
            bus_write(3'd0, 32'hA5);
        join
        check("R2", "8N1 data", d, 8'hA5);
        check("R2", "8N1 start/stop", ok, 1);
    endtask

    task automatic t_tx_7e2;
        logic [7:0] d; logic p, ok;
        configure(8'd1, 8'd0, 8'h4E);
        fork
            capture(BITCLK, 7, 1, 2, d, p, ok);
            bus_write(3'd0, 32'hB5);
        join
        check("R2", "7E2 data", d, 8'h35);
        check("R2", "7E2 parity", p, 0);
        check("R2", "7E2 two stops", ok, 1);
    endtask

    task automatic t_tx_5o1;
        logic [7:0] d; logic p, ok;
        configure(8'd1, 8'd0, 8'h02);
        fork
            capture(BITCLK, 5, 1, 1, d, p, ok);
            bus_write(3'd0, 32'h17);
        join
        check("R2", "5O1 data", d, 8'h17);
        check("R2", "5O1 parity", p, 1);
        check("R2", "5O1 start/stop", ok, 1);
    endtask

    task automatic t_break;
        configure(8'd1, 8'd0, 8'h60);
        bus_write(3'd6, 32'h61);
        repeat (3) @(negedge clk);
        check("R3", "line during break", tx_o, 0);
        bus_write(3'd6, 32'h60);
        repeat (3) @(negedge clk);
        check("R3", "line after break", tx_o, 1);
    endtask

    task automatic t_rx_basic;
        logic [31:0] r;
        configure(8'd1, 8'd0, 8'h60);
        send_rx(BITCLK, 8'h5A, 8, 0, 0, 1);
        check("R11", "irq_rx with data", irq_rx, 1);
        bus_read(3'd2, r);
        check("R5", "rx empty flag clear", r[4], 0);
        bus_read(3'd0, r);
        check("R6", "received byte", r, 32'h5A);
        bus_read(3'd1, r);
        check("R8", "no error, parity off", r, 0);
        check("R11", "irq_rx after read", irq_rx, 0);
        bus_read(3'd0, r);
        check("R6", "empty read returns 0", r, 0);
    endtask

    task automatic t_rx_framing;
        logic [31:0] r;
        configure(8'd1, 8'd0, 8'h60);
        send_rx(BITCLK, 8'h3C, 8, 0, 0, 0);
        bus_read(3'd0, r);
        check("R7", "byte with bad stop", r, 32'h3C);
        bus_read(3'd1, r);
        check("R7", "framing error bit", r, 32'h1);
    endtask

    task automatic t_rx_parity;
        logic [31:0] r;
        configure(8'd1, 8'd0, 8'h66);
        send_rx(BITCLK, 8'h3C, 8, 1, 1, 1);
        bus_read(3'd0, r);
        bus_read(3'd1, r);
        check("R8", "even parity mismatch", r, 32'h2);
        send_rx(BITCLK, 8'h3C, 8, 1, 0, 1);
        bus_read(3'd0, r);
        check("R8", "even parity data", r, 32'h3C);
        bus_read(3'd1, r);
        check("R8", "even parity good", r, 0);
        configure(8'd1, 8'd0, 8'h22);
        send_rx(BITCLK, 8'h2C, 6, 1, 0, 1);
        bus_read(3'd0, r);
        check("R8", "6-bit odd data", r, 32'h2C);
        bus_read(3'd1, r);
        check("R8", "6-bit odd parity good", r, 0);
    endtask

    task automatic t_fifo_off_tx;
        logic [7:0] a, b; logic p, ok1, ok2; logic [31:0] r;
        int lows = 0;
        configure(8'd1, 8'd0, 8'h60);
        fork
            begin
                capture(BITCLK, 8, 0, 1, a, p, ok1);
                capture(BITCLK, 8, 0, 1, b, p, ok2);
            end
            begin
                bus_write(3'd0, 32'h11);
                repeat (3) @(negedge clk);
                bus_write(3'd0, 32'h22);
                bus_read(3'd2, r);
                check("R5", "tx full with single entry", r[5], 1);
                bus_write(3'd0, 32'h33);
            end
        join
        check("R4", "first frame", a, 8'h11);
        check("R4", "second frame", b, 8'h22);
        for (int i = 0; i < 12 * BITCLK; i++) begin
            @(negedge clk);
            if (tx_o == 1'b0) lows++;
        end
        check("R4", "write into full queue dropped", lows, 0);
    endtask

    task automatic t_fifo_off_overrun;
        logic [31:0] r;
        configure(8'd1, 8'd0, 8'h60);
        send_rx(BITCLK, 8'hC1, 8, 0, 0, 1);
        send_rx(BITCLK, 8'hC2, 8, 0, 0, 1);
        bus_read(3'd0, r);
        check("R9", "first byte kept", r, 32'hC1);
        bus_read(3'd1, r);
        check("R9", "first byte clean", r, 0);
        bus_read(3'd2, r);
        check("R9", "discarded byte not queued", r[4], 1);
        send_rx(BITCLK, 8'hC3, 8, 0, 0, 1);
        bus_read(3'd0, r);
        check("R9", "next stored byte", r, 32'hC3);
        bus_read(3'd1, r);
        check("R9", "overrun on next byte", r, 32'h4);
    endtask

    task automatic t_fifo_on_tx;
        logic [31:0] r;
        configure(8'd1, 8'd0, 8'h70);
        for (int i = 0; i < 16; i++) bus_write(3'd0, 32'h40 + i);
        bus_read(3'd2, r);
        check("R4", "15 queued not full", r[5], 0);
        check("R11", "irq_tx with room", irq_tx, 1);
        bus_write(3'd0, 32'h7F);
        bus_read(3'd2, r);
        check("R4", "16 queued full", r[5], 1);
        check("R5", "busy while sending", r[3], 1);
        check("R11", "irq_tx when full", irq_tx, 0);
        bus_write(3'd3, 32'd0);
        repeat (3) @(negedge clk);
        bus_read(3'd2, r);
        check("R10", "parked flags", r, 32'h10);
        check("R10", "parked line high", tx_o, 1);
    endtask

    task automatic t_fifo_on_rx;
        logic [31:0] r;
        configure(8'd1, 8'd0, 8'h70);
        send_rx(BITCLK, 8'h81, 8, 0, 0, 1);
        send_rx(BITCLK, 8'h82, 8, 0, 0, 1);
        send_rx(BITCLK, 8'h83, 8, 0, 0, 1);
        bus_read(3'd0, r); check("R4", "rx queue order 1", r, 32'h81);
        bus_read(3'd0, r); check("R4", "rx queue order 2", r, 32'h82);
        bus_read(3'd0, r); check("R4", "rx queue order 3", r, 32'h83);
        bus_read(3'd1, r); check("R9", "no overrun with depth", r, 0);
    endtask

    task automatic t_parked_rx;
        logic [31:0] r;
        bus_write(3'd3, 32'd0);
        send_rx(BITCLK, 8'h99, 8, 0, 0, 1);
        bus_read(3'd2, r);
        check("R10", "rx ignored while parked", r[4], 1);
        check("R10", "no irq_rx while parked", irq_rx, 0);
    endtask

    task automatic t_div_split;
        int len = 0;
        logic [31:0] r;
        configure(8'h02, 8'hF1, 8'h60);
        fork
            begin
                @(negedge clk);
                while (tx_o !== 1'b0) @(negedge clk);
                while (tx_o === 1'b0) begin
                    len++;
                    @(negedge clk);
                end
            end
            bus_write(3'd0, 32'h01);
        join
        check("R1", "start bit length, divisor 0x102", len, 16 * 259);
        repeat (10 * 16 * 259) @(negedge clk);
        bus_read(3'd2, r);
        check("R5", "idle after frame", r, 32'h10);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        repeat (2) @(negedge clk);
        t_reset();
        t_tx_8n1();
        t_tx_7e2();
        t_tx_5o1();
        t_break();
        t_rx_basic();
        t_rx_framing();
        t_rx_parity();
        t_fifo_off_tx();
        t_fifo_off_overrun();
        t_fifo_on_tx();
        t_fifo_on_rx();
        t_parked_rx();
        t_div_split();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule